// File: doc/BRIEF.md
# Combined PWM Channel Pair with Buffered Output Swap

This block drives one pair of outputs of an edge-aligned PWM timer running in combined mode. A free-running up counter starts at a programmable initial value, climbs to a programmable modulo value and then reloads the initial value; each reload begins a new period. Two compare registers place the edges of the even output inside the period. The first compare match raises the even output's active level and the second match ends it. The odd output is always the complement of the even output.

A per-pair invert control exchanges the two outputs. Software first writes the control into a buffer bit. The buffer is copied into the active bit only on a synchronization event: either a one-cycle strobe, or the counter reaching the modulo value while the modulo-sync enable is set. A two-bit polarity select chooses high-true or low-true levels, and a mode word must describe combined complementary edge-aligned operation before the swap is allowed to act.

The waveform is produced by a three-state phase machine. PH_LEAD is the part of the period before the first match. PH_ACTIVE lies between the two matches. PH_TRAIL lies after the second match. Its transitions are named as follows. START goes from any state to PH_LEAD when the counter equals the initial value. RISE goes to PH_ACTIVE on the even compare match. FALL goes to PH_TRAIL on the odd compare match. FALL takes priority over RISE, and RISE takes priority over START. Both match transitions are taken only when the even compare value is below the odd compare value.

Top module: `pwm_pair_inv`

## Requirements
- R1: A synchronous active-high `rst` clears the counter, both compare registers and both invert bits. On the clock edges where `rst` is high, `count_o` becomes 0 and both outputs become 0.
- R2: `count_o` increments by one on each clock. When it equals `cnt_mod_i`, the next value is `cnt_init_i`.
- R3: With `pol_i` = 2'b10 (high-true) and no swap, the even output is low after the counter shows the initial value. It goes high after the counter shows the even compare value and low after the counter shows the odd compare value. Each change appears on the clock edge after the counter shows the value.
- R4: When `pol_i` is nonzero, `ch_odd_o` is the complement of `ch_even_o`. When `pol_i` = 2'b00, both outputs are driven low.
- R5: With `pol_i[0]` = 1 (low-true), the even output is the complement of the R3 waveform.
- R6: If the even compare value is not less than the odd compare value, the even output keeps its period-start level through the whole period.
- R7: Writing the invert buffer (`inv_buf_we_i`) has no effect on the outputs until a synchronization event occurs.
- R8: `sync_pulse_i` high for one cycle copies the buffer bit into the active invert bit. The outputs appear swapped starting on that same clock edge.
- R9: When `sync_at_mod_i` = 1, the counter showing `cnt_mod_i` is a synchronization event. When `sync_at_mod_i` = 0, it is not.
- R10: The swap acts only when the mode bits are `mode_i[0]`=1 (enhanced), `[1]`=0 (quadrature), `[2]`=0 (dual capture), `[3]`=1 (combine), `[4]`=1 (complement) and `[5]`=0 (center-aligned). Any other mode leaves the outputs unswapped.
- R11: `cmp_wr_even_i` and `cmp_wr_odd_i` load `cmp_wdata_i` into the even and odd compare registers respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_init_i | input | CNT_W | Counter reload (period start) value |
| cnt_mod_i | input | CNT_W | Counter modulo (period end) value |
| cmp_wr_even_i | input | 1 | Write strobe for the even compare register |
| cmp_wr_odd_i | input | 1 | Write strobe for the odd compare register |
| cmp_wdata_i | input | CNT_W | Compare write data |
| mode_i | input | 6 | Mode word gating the swap (see R10) |
| pol_i | input | 2 | Polarity select: 10 high-true, x1 low-true, 00 off |
| inv_buf_we_i | input | 1 | Write strobe for the invert buffer bit |
| inv_buf_d_i | input | 1 | Invert buffer write data |
| sync_pulse_i | input | 1 | One-cycle synchronization strobe |
| sync_at_mod_i | input | 1 | Enables synchronization at the modulo value |
| count_o | output | CNT_W | Current counter value |
| ch_even_o | output | 1 | Even channel output |
| ch_odd_o | output | 1 | Odd channel output |

## Verification
On every cycle, the assertions check the following: the counter's increment and reload, the reset values, the complementary relation between the outputs, the forced-low state when polarity is off, and the invert bit's behaviour (it is loaded only on a synchronization event and holds otherwise). The shape of the waveform cannot be seen by these local properties. Its edge placement against the two compare values, the empty period when the compare order is wrong, low-true levels and mode gating of the swap are shown only by the bench. The bench sweeps every ordering of the compare values across a short period, under each polarity and swap setting, and also runs directed synchronization scenarios.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    // Phase of the even output within the current period
    typedef enum logic [1:0] {
        PH_LEAD   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_TRAIL  = 2'd2
    } phase_e;

    localparam int MODE_W    = 6;
    localparam int MB_ENH    = 0;
    localparam int MB_QUAD   = 1;
    localparam int MB_DCAP   = 2;
    localparam int MB_COMB   = 3;
    localparam int MB_COMP   = 4;
    localparam int MB_CENTER = 5;

    // Swap is only legal in enhanced, combined, complementary, edge-aligned operation
    function automatic logic swap_allowed(input logic [MODE_W-1:0] m);
        return m[MB_ENH] & ~m[MB_QUAD] & ~m[MB_DCAP] &
               m[MB_COMB] & m[MB_COMP] & ~m[MB_CENTER];
    endfunction

endpackage

// File: rtl/pair_counter.sv
module pair_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_val,
    input  logic             sync_pulse,
    input  logic             sync_at_mod,
    output logic [CNT_W-1:0] count,
    output logic             at_init,
    output logic             sync_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic at_mod;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (at_mod) begin
            count <= init_val;
        end else begin
            count <= count + ONE;
        end
    end

    always_comb begin
        at_mod   = (count == mod_val);
        at_init  = (count == init_val);
        sync_evt = sync_pulse | (sync_at_mod & at_mod);
    end

endmodule

// File: rtl/pair_cmp_regs.sv
module pair_cmp_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_even,
    input  logic             wr_odd,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] count,
    output logic             hit_even,
    output logic             hit_odd,
    output logic             edges_ok
);
    localparam int NCMP = 2;

    logic [NCMP-1:0]  wr_vec;
    logic [CNT_W-1:0] cmp_q [NCMP];
    logic [NCMP-1:0]  hit_vec;

    assign wr_vec = {wr_odd, wr_even};

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[g] <= '0;
            end else if (wr_vec[g]) begin
                cmp_q[g] <= wdata;
            end
        end
        assign hit_vec[g] = (count == cmp_q[g]);
    end

    always_comb begin
        hit_even = hit_vec[0];
        hit_odd  = hit_vec[1];
        edges_ok = (cmp_q[0] < cmp_q[1]);
    end

endmodule

// File: rtl/pair_phase_fsm.sv
module pair_phase_fsm
    import pwm_pair_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   at_init,
    input  logic   hit_even,
    input  logic   hit_odd,
    input  logic   edges_ok,
    output phase_e state_q,
    output phase_e state_n
);
    logic rise_ev;
    logic fall_ev;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_LEAD;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state: FALL beats RISE beats START
    always_comb begin
        rise_ev = edges_ok & hit_even;
        fall_ev = edges_ok & hit_odd;
        state_n = state_q;
        unique case (state_q)
            PH_LEAD: begin
                if (fall_ev)      state_n = PH_TRAIL;
                else if (rise_ev) state_n = PH_ACTIVE;
                else              state_n = PH_LEAD;
            end
            PH_ACTIVE: begin
                if (fall_ev)      state_n = PH_TRAIL;
                else if (rise_ev) state_n = PH_ACTIVE;
                else if (at_init) state_n = PH_LEAD;
            end
            PH_TRAIL: begin
                if (fall_ev)      state_n = PH_TRAIL;
                else if (rise_ev) state_n = PH_ACTIVE;
                else if (at_init) state_n = PH_LEAD;
            end
            default: state_n = PH_LEAD;
        endcase
    end

endmodule

// File: rtl/pair_inv_ctrl.sv
module pair_inv_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic buf_we,
    input  logic buf_d,
    input  logic sync_evt,
    output logic inv_buf_q,
    output logic inv_act_q,
    output logic inv_act_n
);
    // Active bit takes the buffer value held before this edge
    always_comb begin
        inv_act_n = sync_evt ? inv_buf_q : inv_act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_buf_q <= 1'b0;
            inv_act_q <= 1'b0;
        end else begin
            inv_act_q <= inv_act_n;
            if (buf_we) begin
                inv_buf_q <= buf_d;
            end
        end
    end

endmodule

// File: rtl/pwm_pair_inv.sv
module pwm_pair_inv
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_init_i,
    input  logic [CNT_W-1:0]  cnt_mod_i,
    input  logic              cmp_wr_even_i,
    input  logic              cmp_wr_odd_i,
    input  logic [CNT_W-1:0]  cmp_wdata_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [1:0]        pol_i,
    input  logic              inv_buf_we_i,
    input  logic              inv_buf_d_i,
    input  logic              sync_pulse_i,
    input  logic              sync_at_mod_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              ch_even_o,
    output logic              ch_odd_o
);
    logic   at_init;
    logic   sync_evt;
    logic   hit_even;
    logic   hit_odd;
    logic   edges_ok;
    phase_e state_q;
    phase_e state_n;
    logic   inv_buf_q;
    logic   inv_act_q;
    logic   inv_act_n;
    logic   active_lvl;
    logic   base_lvl;
    logic   swap;
    logic   even_n;
    logic   odd_n;

    pair_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .init_val   (cnt_init_i),
        .mod_val    (cnt_mod_i),
        .sync_pulse (sync_pulse_i),
        .sync_at_mod(sync_at_mod_i),
        .count      (count_o),
        .at_init    (at_init),
        .sync_evt   (sync_evt)
    );

    pair_cmp_regs #(.CNT_W(CNT_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .wr_even (cmp_wr_even_i),
        .wr_odd  (cmp_wr_odd_i),
        .wdata   (cmp_wdata_i),
        .count   (count_o),
        .hit_even(hit_even),
        .hit_odd (hit_odd),
        .edges_ok(edges_ok)
    );

    pair_phase_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .at_init (at_init),
        .hit_even(hit_even),
        .hit_odd (hit_odd),
        .edges_ok(edges_ok),
        .state_q (state_q),
        .state_n (state_n)
    );

    pair_inv_ctrl u_inv (
        .clk      (clk),
        .rst      (rst),
        .buf_we   (inv_buf_we_i),
        .buf_d    (inv_buf_d_i),
        .sync_evt (sync_evt),
        .inv_buf_q(inv_buf_q),
        .inv_act_q(inv_act_q),
        .inv_act_n(inv_act_n)
    );

    // Output decode from next phase and next invert state
    always_comb begin
        active_lvl = (state_n == PH_ACTIVE);
        base_lvl   = pol_i[0] ? ~active_lvl : active_lvl;
        swap       = inv_act_n & swap_allowed(mode_i);
        if (pol_i == 2'b00) begin
            even_n = 1'b0;
            odd_n  = 1'b0;
        end else begin
            even_n = swap ? ~base_lvl : base_lvl;
            odd_n  = ~even_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_even_o <= 1'b0;
            ch_odd_o  <= 1'b0;
        end else begin
            ch_even_o <= even_n;
            ch_odd_o  <= odd_n;
        end
    end

endmodule

// File: rtl/pwm_pair_inv_chk.sv
module pwm_pair_inv_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] cnt_init_i,
    input logic [CNT_W-1:0] cnt_mod_i,
    input logic [1:0]       pol_i,
    input logic             ch_even_o,
    input logic             ch_odd_o,
    input logic             sync_pulse_i,
    input logic             sync_at_mod_i,
    input logic             inv_buf,
    input logic             inv_act
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !ch_even_o && !ch_odd_o));

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (count_o != cnt_mod_i) |=> (count_o == CNT_W'($past(count_o) + ONE)));

    p_count_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (count_o == cnt_mod_i) |=> (count_o == $past(cnt_init_i)));

    p_complement_r4: assert property (@(posedge clk) disable iff (rst)
        (pol_i != 2'b00) |=> (ch_odd_o != ch_even_o));

    p_pol_off_r4: assert property (@(posedge clk) disable iff (rst)
        (pol_i == 2'b00) |=> (!ch_even_o && !ch_odd_o));

    p_inv_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!sync_pulse_i && !(sync_at_mod_i && count_o == cnt_mod_i)) |=> $stable(inv_act));

    p_inv_load_r8: assert property (@(posedge clk) disable iff (rst)
        sync_pulse_i |=> (inv_act == $past(inv_buf)));

    p_mod_sync_r9: assert property (@(posedge clk) disable iff (rst)
        (sync_at_mod_i && count_o == cnt_mod_i) |=> (inv_act == $past(inv_buf)));

endmodule

bind pwm_pair_inv pwm_pair_inv_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .count_o      (count_o),
    .cnt_init_i   (cnt_init_i),
    .cnt_mod_i    (cnt_mod_i),
    .pol_i        (pol_i),
    .ch_even_o    (ch_even_o),
    .ch_odd_o     (ch_odd_o),
    .sync_pulse_i (sync_pulse_i),
    .sync_at_mod_i(sync_at_mod_i),
    .inv_buf      (inv_buf_q),
    .inv_act      (inv_act_q)
);

// File: tb/pwm_pair_inv_test.sv
module pwm_pair_inv_test;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int PI = 2;   // period start
    localparam int PM = 9;   // period end
    localparam logic [5:0] MODE_OK = 6'b011001;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] cnt_init_i = W'(PI);
    logic [W-1:0] cnt_mod_i  = W'(PM);
    logic         cmp_wr_even_i = 1'b0;
    logic         cmp_wr_odd_i  = 1'b0;
    logic [W-1:0] cmp_wdata_i   = '0;
    logic [5:0]   mode_i = MODE_OK;
    logic [1:0]   pol_i  = 2'b10;
    logic         inv_buf_we_i = 1'b0;
    logic         inv_buf_d_i  = 1'b0;
    logic         sync_pulse_i = 1'b0;
    logic         sync_at_mod_i = 1'b0;
    logic [W-1:0] count_o;
    logic         ch_even_o;
    logic         ch_odd_o;

    int n_chk = 0;
    int n_fail = 0;
    int prev = 0;
    int cur = 0;
    bit have_prev = 0;
    int c0 = 0;
    int c1 = 0;
    bit invv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_pair_inv #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .cnt_init_i(cnt_init_i), .cnt_mod_i(cnt_mod_i),
        .cmp_wr_even_i(cmp_wr_even_i), .cmp_wr_odd_i(cmp_wr_odd_i),
        .cmp_wdata_i(cmp_wdata_i), .mode_i(mode_i), .pol_i(pol_i),
        .inv_buf_we_i(inv_buf_we_i), .inv_buf_d_i(inv_buf_d_i),
        .sync_pulse_i(sync_pulse_i), .sync_at_mod_i(sync_at_mod_i),
        .count_o(count_o), .ch_even_o(ch_even_o), .ch_odd_o(ch_odd_o)
    );

    function automatic bit mode_lets_swap(input logic [5:0] m);
        return m[0] & ~m[1] & ~m[2] & m[3] & m[4] & ~m[5];
    endfunction

    // {odd, even} expected after the counter showed p on the previous cycle
    function automatic logic [1:0] exp_out(input int p);
        bit act;
        bit lvl;
        act = (c0 < c1) && (c0 <= p) && (p < c1);
        if (pol_i == 2'b00) return 2'b00;
        lvl = pol_i[0] ? ~act : act;
        if (invv && mode_lets_swap(mode_i)) lvl = ~lvl;
        return {~lvl, lvl};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (c0=%0d c1=%0d pol=%b inv=%0d mode=%b prev=%0d)",
                     tag, act, exp, c0, c1, pol_i, invv, mode_i, prev);
        end
    endtask

    task automatic step(input bit do_chk, input string tag);
        @(posedge clk);
        @(negedge clk);
        cur = int'(count_o);
        if (have_prev) check("R2", cur, (prev == PM) ? PI : prev + 1);
        if (do_chk) check(tag, int'({ch_odd_o, ch_even_o}), int'(exp_out(prev)));
        prev = cur;
        have_prev = 1;
    endtask

    task automatic run_to(input int v, input bit do_chk, input string tag);
        do step(do_chk, tag); while (cur != v);
    endtask

    task automatic run_checked(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1, tag);
    endtask

    // R11: compare registers written through the write strobes
    task automatic load_cmps(input int e, input int o);
        cmp_wdata_i = W'(e); cmp_wr_even_i = 1'b1;
        step(0, "");
        cmp_wr_even_i = 1'b0; cmp_wdata_i = W'(o); cmp_wr_odd_i = 1'b1;
        step(0, "");
        cmp_wr_odd_i = 1'b0;
        c0 = e; c1 = o;
    endtask

    task automatic set_inv(input bit v);
        inv_buf_d_i = v; inv_buf_we_i = 1'b1;
        step(0, "");
        inv_buf_we_i = 1'b0; sync_pulse_i = 1'b1;
        step(0, "");
        sync_pulse_i = 1'b0;
        invv = v;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 count", int'(count_o), 0);
        check("R1 outputs", int'({ch_odd_o, ch_even_o}), 0);
        rst = 1'b0;
        prev = 0; have_prev = 1;
        // R1: cleared compares give an empty period, cleared invert gives no swap
        run_to(PI, 0, ""); run_to(PM, 0, "");
        run_checked(PM - PI + 1, "R1 cleared state");

        // Sweep of compare orderings, polarity and swap
        for (int ps = 0; ps < 3; ps++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int e = PI; e <= PM + 2; e++) begin
                    for (int o = PI; o <= PM + 2; o++) begin
                        string tag;
                        pol_i = (ps == 0) ? 2'b10 : ((ps == 1) ? 2'b01 : 2'b11);
                        load_cmps(e, o);
                        set_inv(iv[0]);
                        run_to(PI, 0, ""); run_to(PM, 0, "");
                        if (ps != 0)     tag = "R5 R11";
                        else if (e < o)  tag = "R3 R11";
                        else             tag = "R6 R11";
                        if (iv != 0) tag = {tag, " R8"};
                        run_checked(2 * (PM - PI + 1), tag);
                    end
                end
            end
        end

        // Directed: buffer write without sync
        pol_i = 2'b10;
        load_cmps(4, 7);
        set_inv(1'b0);
        run_to(PI, 0, "");
        inv_buf_d_i = 1'b1; inv_buf_we_i = 1'b1;
        step(1, "R7");
        inv_buf_we_i = 1'b0;
        run_checked(2 * (PM - PI + 1), "R7 buffer only");
        // Strobe applies it on the next edge
        sync_pulse_i = 1'b1; invv = 1'b1;
        step(1, "R8 strobe");
        sync_pulse_i = 1'b0;
        run_checked(PM - PI + 1, "R8 after strobe");

        // Modulo sync disabled: no change at the end of the period
        run_to(PI, 1, "R8");
        inv_buf_d_i = 1'b0; inv_buf_we_i = 1'b1;
        step(1, "R7");
        inv_buf_we_i = 1'b0;
        run_checked(2 * (PM - PI + 1), "R9 disabled");
        // Modulo sync enabled
        sync_at_mod_i = 1'b1;
        run_to(PM, 1, "R9 before modulo");
        invv = 1'b0;
        step(1, "R9 at modulo");
        run_checked(PM - PI, "R9 after modulo");
        sync_at_mod_i = 1'b0;

        // R10: each mode bit flipped away from the permitted pattern
        set_inv(1'b1);
        for (int b = 0; b < 6; b++) begin
            mode_i = MODE_OK ^ (6'b1 << b);
            run_checked(PM - PI + 1, "R10 mode gate");
        end
        mode_i = MODE_OK;
        run_checked(PM - PI + 1, "R10 mode permitted");

        // R4: polarity off
        pol_i = 2'b00;
        run_checked(PM - PI + 1, "R4 polarity off");
        pol_i = 2'b10;
        run_checked(PM - PI + 1, "R4 complement");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule